// File: doc/BRIEF.md
# Indexed Palette DAC Write Port

This block holds a colour lookup table of 256 entries, each made of a red, a green and a blue component of 8 bits. Software loads it through an index/data register pair on a byte-wide register bus, in the classic VGA manner. Software writes an entry number into the index register, then writes bytes into the data register. Each data write fills the next component of the current entry: red, then green, then blue. After blue the block moves to the next entry.

Components are stored at their full 8-bit width with no shift or scaling. A one-cycle redraw request goes out whenever a data write changes a stored byte. Rewriting the value already held raises no request. The display side reads the table through a combinational lookup port: it presents an entry number and gets back the three components in the same cycle.

Top module: `palette_dac_port`

## Requirements
- R1: A write with `reg_sel`=1 and `reg_off`=8 loads `reg_wdata[7:0]` into the entry index and resets the component pointer to red.
- R2: A write with `reg_sel`=1 and `reg_off`=9 stores `reg_wdata[7:0]` unchanged into the component of the current entry that the pointer selects (0 = red, 1 = green, 2 = blue). After the clock edge the value is visible on the lookup port.
- R3: Each data write advances the component pointer red → green → blue. After a blue write the pointer goes back to red and the entry index increments by one.
- R4: The entry index increments from 255 to 0.
- R5: `redraw` is high for exactly the one cycle after a data write that changed the stored byte. It stays low after a data write of the byte already held, and after any other access.
- R6: While `reg_sel`=1 and `reg_off`=8, `reg_rdata` shows the current entry index. At every other offset, and while `reg_sel`=0, it reads 0.
- R7: After reset every component of every entry is 0, the index is 0, the pointer selects red and `redraw` is low.
- R8: A write at any offset other than 8 or 9, or while `reg_sel`=0, changes neither the table, the index nor the pointer.
- R9: `lut_red`, `lut_green` and `lut_blue` follow `lut_index` combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register window selected |
| reg_off | input | 5 | Byte offset inside the 32-byte window |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (entry index at offset 8) |
| redraw | output | 1 | One-cycle full-redraw request |
| lut_index | input | 8 | Lookup entry number |
| lut_red | output | 8 | Red component of the looked-up entry |
| lut_green | output | 8 | Green component of the looked-up entry |
| lut_blue | output | 8 | Blue component of the looked-up entry |

## Verification
The hardest state to reach from the ports is a data write that lands on a component whose stored byte already equals the new value. Only that case separates "write happened" from "value changed" for the redraw request. The stimulus reaches it by rewinding the index and replaying the same bytes, and by drawing data from a small value set so that repeats happen often. The index wrap is reached by loading entry 255 and streaming data writes across the end of the table. All of this runs against a behavioural model that is compared on every clock.

// File: rtl/pal_pkg.sv
package pal_pkg;
   localparam int NUM_COMP = 3;
   typedef enum logic [1:0] {
      COMP_R = 2'd0,
      COMP_G = 2'd1,
      COMP_B = 2'd2
   } comp_e;
endpackage

// File: rtl/pal_pointer.sv
module pal_pointer
   import pal_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [IDX_W-1:0] load_val,
   input  logic             step_en,
   output logic [IDX_W-1:0] idx,
   output comp_e            comp
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx  <= '0;
         comp <= COMP_R;
      end else if (load_en) begin
         idx  <= load_val;
         comp <= COMP_R;
      end else if (step_en) begin
         if (comp == COMP_B) begin
            comp <= COMP_R;
            idx  <= idx + 1'b1;
         end else begin
            comp <= comp_e'(comp + 2'd1);
         end
      end
   end

   AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (idx == $past(load_val)) && (comp == COMP_R)); // R1
   AST_ENTRY_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load_en && comp == COMP_B) |=> (comp == COMP_R) && (idx == IDX_W'($past(idx) + 1'b1))); // R3
   AST_POINTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en && !load_en) |=> $stable(idx) && $stable(comp)); // R8
endmodule

// File: rtl/pal_bank.sv
module pal_bank #(
   parameter int IDX_W  = 8,
   parameter int COMP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [COMP_W-1:0] wr_val,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [COMP_W-1:0] rd_val,
   output logic              differs
);
   localparam int DEPTH = 1 << IDX_W;

   logic [COMP_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[wr_idx] <= wr_val;
      end
   end

   assign rd_val  = mem[rd_idx];
   assign differs = (mem[wr_idx] != wr_val);

   AST_BANK_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(wr_idx)] == $past(wr_val)); // R2
endmodule

// File: rtl/palette_dac_port.sv
module palette_dac_port
   import pal_pkg::*;
#(
   parameter int IDX_W   = 8,
   parameter int COMP_W  = 8,
   parameter int BUS_W   = 8,
   parameter int OFF_W   = 5,
   parameter int IDX_OFF = 8,
   parameter int DAT_OFF = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic [OFF_W-1:0]  reg_off,
   input  logic              reg_we,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   output logic              redraw,
   input  logic [IDX_W-1:0]  lut_index,
   output logic [COMP_W-1:0] lut_red,
   output logic [COMP_W-1:0] lut_green,
   output logic [COMP_W-1:0] lut_blue
);
   localparam int WINDOW = 1 << OFF_W;

   if (COMP_W > BUS_W) begin : g_chk_comp
      $error("component wider than the register bus");
   end
   if (IDX_W > BUS_W) begin : g_chk_idx
      $error("entry index wider than the register bus");
   end
   if (IDX_OFF == DAT_OFF || IDX_OFF >= WINDOW || DAT_OFF >= WINDOW) begin : g_chk_off
      $error("register offsets overlap or fall outside the window");
   end

   logic              hit_idx, hit_dat, idx_wr, dat_wr;
   logic [IDX_W-1:0]  cur_idx;
   comp_e             cur_comp;
   logic [NUM_COMP-1:0] bank_we, bank_diff;
   logic [COMP_W-1:0] bank_rd [NUM_COMP];
   logic              redraw_q;

   assign hit_idx = reg_sel && (reg_off == OFF_W'(IDX_OFF));
   assign hit_dat = reg_sel && (reg_off == OFF_W'(DAT_OFF));
   assign idx_wr  = hit_idx && reg_we;
   assign dat_wr  = hit_dat && reg_we;

   pal_pointer #(.IDX_W(IDX_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (idx_wr),
      .load_val (reg_wdata[IDX_W-1:0]),
      .step_en  (dat_wr),
      .idx      (cur_idx),
      .comp     (cur_comp)
   );

   for (genvar k = 0; k < NUM_COMP; k++) begin : g_bank
      assign bank_we[k] = dat_wr && (cur_comp == 2'(k));
      pal_bank #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .we      (bank_we[k]),
         .wr_idx  (cur_idx),
         .wr_val  (reg_wdata[COMP_W-1:0]),
         .rd_idx  (lut_index),
         .rd_val  (bank_rd[k]),
         .differs (bank_diff[k])
      );
   end

   assign lut_red   = bank_rd[0];
   assign lut_green = bank_rd[1];
   assign lut_blue  = bank_rd[2];

   always_ff @(posedge clk) begin
      if (!rst_n) redraw_q <= 1'b0;
      else        redraw_q <= |(bank_we & bank_diff);
   end
   assign redraw = redraw_q;

   always_comb begin
      reg_rdata = '0;
      if (hit_idx) reg_rdata[IDX_W-1:0] = cur_idx;
   end

   AST_REDRAW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      redraw |-> $past(dat_wr)); // R5
   AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_we)); // R3
endmodule

// File: tb/sim_palette_dac_port.sv
module sim_palette_dac_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_sel = 1'b0;
   logic [4:0] reg_off = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       redraw;
   logic [7:0] lut_index = '0;
   logic [7:0] lut_red, lut_green, lut_blue;

   int checks = 0;
   int bad = 0;

   int pal [768];
   int m_idx = 0;
   int m_sub = 0;
   int m_red = 0;

   always #2.5 clk = ~clk;

   palette_dac_port u0 (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_off(reg_off),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .redraw(redraw), .lut_index(lut_index), .lut_red(lut_red),
      .lut_green(lut_green), .lut_blue(lut_blue)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock of stimulus, model update and comparison of every output
   task automatic cycle(string tag, bit s, bit w, int off, int d, int li);
      int nidx, nsub, nred, p;
      @(negedge clk);
      reg_sel = s; reg_we = w; reg_off = off[4:0]; reg_wdata = d[7:0]; lut_index = li[7:0];
      nidx = m_idx; nsub = m_sub; nred = 0;
      if (s && w && off == 8) begin
         nidx = d & 255; nsub = 0;
      end else if (s && w && off == 9) begin
         p = m_idx * 3 + m_sub;
         nred = (pal[p] != (d & 255)) ? 1 : 0;
         pal[p] = d & 255;
         if (m_sub == 2) begin nsub = 0; nidx = (m_idx + 1) % 256; end
         else nsub = m_sub + 1;
      end
      @(posedge clk);
      #1;
      m_idx = nidx; m_sub = nsub; m_red = nred;
      chk({tag, " R5 redraw"}, int'(redraw), m_red);
      chk({tag, " R6 rdata"}, int'(reg_rdata), (s && off == 8) ? m_idx : 0);
      chk({tag, " R2 red"},   int'(lut_red),   pal[li*3]);
      chk({tag, " R2 green"}, int'(lut_green), pal[li*3+1]);
      chk({tag, " R2 blue"},  int'(lut_blue),  pal[li*3+2]);
   endtask

   task automatic peek_index(string tag);
      @(negedge clk);
      reg_sel = 1'b1; reg_we = 1'b0; reg_off = 5'd8;
      #1;
      chk({tag, " index"}, int'(reg_rdata), m_idx);
   endtask

   initial begin
      for (int i = 0; i < 768; i++) pal[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R7: reset contents, index, no redraw
      for (int e = 0; e < 256; e++) cycle("R7 reset sweep", 0, 0, 0, 0, e);
      peek_index("R7");

      // R1: index load
      cycle("R1 load", 1, 1, 8, 17, 17);
      peek_index("R1");
      // R2/R3: three components then next entry
      cycle("R2 red", 1, 1, 9, 8'hA5, 17);
      cycle("R2 green", 1, 1, 9, 8'hFF, 17);
      cycle("R2 blue", 1, 1, 9, 8'h01, 17);
      peek_index("R3 advance");
      cycle("R3 next red", 1, 1, 9, 8'h3C, 18);
      // R1: reload mid-entry resets pointer to red
      cycle("R1 reload", 1, 1, 8, 17, 17);
      // R5: same values give no redraw
      cycle("R5 same red", 1, 1, 9, 8'hA5, 17);
      cycle("R5 same green", 1, 1, 9, 8'hFF, 17);
      cycle("R5 change blue", 1, 1, 9, 8'h02, 17);
      // R4: wrap from 255 to 0
      cycle("R4 load 255", 1, 1, 8, 255, 255);
      cycle("R4 r", 1, 1, 9, 9, 255);
      cycle("R4 g", 1, 1, 9, 10, 255);
      cycle("R4 b", 1, 1, 9, 11, 255);
      peek_index("R4 wrap");
      cycle("R4 entry0", 1, 1, 9, 77, 0);
      // R8: ignored writes
      cycle("R8 unselected", 0, 1, 9, 200, 0);
      cycle("R8 other off", 1, 1, 3, 200, 0);
      cycle("R8 unsel idx", 0, 1, 8, 99, 0);
      peek_index("R8");
      cycle("R8 follow", 1, 1, 9, 55, 0);
      // R9: lookup follows index with no write
      for (int e = 250; e < 256; e++) cycle("R9 lookup", 0, 0, 0, 0, e);

      // random traffic, small value set to make repeats common
      for (int n = 0; n < 3000; n++) begin
         int r, off, d;
         r = $urandom_range(0, 9);
         if (r == 0)      begin off = 8; d = $urandom_range(0, 7) * 37 % 256; end
         else if (r < 8)  begin off = 9; d = $urandom_range(0, 3); end
         else             begin off = $urandom_range(0, 31); d = $urandom_range(0, 255); end
         cycle("R3 random", $urandom_range(0, 7) != 0, $urandom_range(0, 5) != 0,
               off, d, $urandom_range(0, 7) * 37 % 256);
      end

      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule